// File: doc/BRIEF.md
# Boot ROM Overlay Address Decoder

This block generates the two memory chip selects for a processor with a 24-bit address bus. Normally the top address bit alone splits the space. When it is 1, the ROM is enabled and covers the upper 8 MB. When it is 0, the RAM is enabled and covers the lower 8 MB. Only the low address bits reach the ROM, so the ROM image repeats at every multiple of its size throughout the upper half.

At reset an overlay state is armed. It forces the top address bit seen by the memories to 1, so the processor fetches its reset vectors and first instructions from ROM at address zero. While the overlay is armed, RAM cannot be reached. Start-up code jumps into the upper ROM image and then writes a key value to a dedicated I/O address, which clears the overlay. Low memory then becomes RAM, where the interrupt vectors can be rewritten.

A mode input selects how the clear takes effect. In immediate mode the clear takes effect at once. In deferred mode the overlay is held through a set number of further completed bus cycles, so the fetch of the jump out of the low ROM image is not cut off. All outputs are registered and follow their inputs by one clock.

Top module: `boot_overlay_decoder`

## Requirements
- R1: While `rst` is sampled high, the next outputs are `rom_cs_n`=1, `ram_cs_n`=1 and `eff_a23`=1, and the overlay is armed.
- R2: While the overlay is armed, a cycle with `addr_strobe`=1 drives `rom_cs_n` low and `ram_cs_n` high one clock later, for any address. `eff_a23` is then 1.
- R3: Once the overlay is cleared, a strobed address with bit 23 = 1 selects the ROM and one with bit 23 = 0 selects the RAM, one clock later. `eff_a23` equals address bit 23.
- R4: Both selects are active low and never low together. Both are high one clock after a cycle with `addr_strobe`=0.
- R5: Outputs are registered. Each output reflects the inputs and the overlay state sampled at the previous rising edge.
- R6: The overlay is cleared only when `io_wr`=1, `addr` equals IO_ADDR (default 24'hFFFFF0) and `io_data` equals CLEAR_KEY (default 8'h5A). An I/O write with any other address or data has no effect.
- R7: With `defer_en`=0 at the clearing write, the overlay is already cleared for a strobe sampled at the next edge.
- R8: With `defer_en`=1 at the clearing write, the overlay stays armed through the next DEFER_CYCLES (default 2) bus-cycle completions. A completion is a cycle with `addr_strobe`=0 that follows a cycle with `addr_strobe`=1. The overlay clears at the edge that samples the last of these completions. A completion sampled in the same cycle as the write is not counted.
- R9: Further clearing writes, whether made while a deferred clear is pending or after the clear, change nothing. Only reset re-arms the overlay.
- R10: With the overlay cleared, all strobed addresses 0x800000, 0x840000, 0x880000, 0xFC0000 and 0xFFFFFF select the ROM, whatever bits 22..0 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; arms the overlay |
| addr | input | 24 | Processor address bus |
| addr_strobe | input | 1 | High while a memory bus cycle is in progress |
| io_wr | input | 1 | I/O write strobe |
| io_data | input | 8 | I/O write data |
| defer_en | input | 1 | 1 = deferred clear, 0 = immediate clear; sampled at the clearing write |
| rom_cs_n | output | 1 | Active-low ROM select |
| ram_cs_n | output | 1 | Active-low RAM select |
| eff_a23 | output | 1 | Effective address bit 23 presented to the memories |

## Verification
The critical coincidence is a clearing I/O write landing in the same cycle as a bus-cycle completion. When the overlay is armed, that completion must not count toward the deferred window. When a clear is already pending, the second write must be ignored while the completion still counts. Directed sequences end a strobe exactly on the write cycle in both states. Random traffic then mixes writes, strobe edges and resets. Every output is compared each cycle against a bench model of the overlay state that is built from the requirements.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;

  // Overlay life cycle: armed at reset, optionally waiting, then cleared.
  typedef enum logic [1:0] {
    OVL_ARMED   = 2'd0,
    OVL_WAITING = 2'd1,
    OVL_OPEN    = 2'd2
  } ovl_state_e;

  // Effective top bit: the overlay forces the upper half.
  function automatic logic eff_top(input logic a_top, input logic armed);
    return a_top | armed;
  endfunction

endpackage

// File: rtl/ovl_bus_watch.sv
module ovl_bus_watch #(
  parameter int                ADDR_W    = 24,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] IO_ADDR   = 24'hFFFFF0,
  parameter logic [DATA_W-1:0] CLEAR_KEY = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_strobe,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_data,
  output logic              wr_hit,
  output logic              bus_end
);

  logic strobe_q;

  // Remember the strobe of the previous cycle to spot the end of a bus cycle.
  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= addr_strobe;
  end

  assign bus_end = strobe_q & ~addr_strobe;

  // Clearing write: the dedicated location and the key value together.
  assign wr_hit = io_wr && (addr == IO_ADDR) && (io_data == CLEAR_KEY);

endmodule

// File: rtl/ovl_latch.sv
module ovl_latch
  import boot_ovl_pkg::*;
#(
  parameter int DEFER_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic defer_en,
  input  logic wr_hit,
  input  logic bus_end,
  output logic overlay,
  output logic pending
);

  generate
    if (DEFER_CYCLES == 0) begin : g_immediate
      logic armed_q;
      always_ff @(posedge clk) begin
        if (rst)         armed_q <= 1'b1;
        else if (wr_hit) armed_q <= 1'b0;
      end
      assign overlay = armed_q;
      assign pending = 1'b0;
    end else begin : g_deferred
      localparam int             CNT_W = $clog2(DEFER_CYCLES + 1);
      localparam logic [CNT_W-1:0] LOAD = CNT_W'(DEFER_CYCLES);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

      ovl_state_e       state_q;
      logic [CNT_W-1:0] left_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          state_q <= OVL_ARMED;
          left_q  <= '0;
        end else begin
          case (state_q)
            OVL_ARMED: begin
              if (wr_hit) begin
                if (defer_en) begin
                  state_q <= OVL_WAITING;
                  left_q  <= LOAD;
                end else begin
                  state_q <= OVL_OPEN;
                end
              end
            end
            OVL_WAITING: begin
              if (bus_end) begin
                if (left_q == LAST) state_q <= OVL_OPEN;
                else                left_q  <= left_q - LAST;
              end
            end
            default: state_q <= OVL_OPEN;
          endcase
        end
      end

      assign overlay = (state_q != OVL_OPEN);
      assign pending = (state_q == OVL_WAITING);
    end
  endgenerate

endmodule

// File: rtl/ovl_select.sv
module ovl_select
  import boot_ovl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_top,
  input  logic addr_strobe,
  input  logic overlay,
  output logic rom_cs_n,
  output logic ram_cs_n,
  output logic eff_a23
);

  logic top_eff;
  assign top_eff = eff_top(a_top, overlay);

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs_n <= 1'b1;
      ram_cs_n <= 1'b1;
      eff_a23  <= 1'b1;
    end else begin
      rom_cs_n <= ~(addr_strobe & top_eff);
      ram_cs_n <= ~(addr_strobe & ~top_eff);
      eff_a23  <= top_eff;
    end
  end

endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder #(
  parameter int                ADDR_W       = 24,
  parameter int                DATA_W       = 8,
  parameter logic [ADDR_W-1:0] IO_ADDR      = 24'hFFFFF0,
  parameter logic [DATA_W-1:0] CLEAR_KEY    = 8'h5A,
  parameter int                DEFER_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_strobe,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_data,
  input  logic              defer_en,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              eff_a23
);

  localparam int TOP = ADDR_W - 1;

  logic wr_hit;
  logic bus_end;
  logic overlay;
  logic pending;

  ovl_bus_watch #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IO_ADDR   (IO_ADDR),
    .CLEAR_KEY (CLEAR_KEY)
  ) u_watch (
    .clk         (clk),
    .rst         (rst),
    .addr        (addr),
    .addr_strobe (addr_strobe),
    .io_wr       (io_wr),
    .io_data     (io_data),
    .wr_hit      (wr_hit),
    .bus_end     (bus_end)
  );

  ovl_latch #(
    .DEFER_CYCLES (DEFER_CYCLES)
  ) u_latch (
    .clk      (clk),
    .rst      (rst),
    .defer_en (defer_en),
    .wr_hit   (wr_hit),
    .bus_end  (bus_end),
    .overlay  (overlay),
    .pending  (pending)
  );

  ovl_select u_sel (
    .clk         (clk),
    .rst         (rst),
    .a_top       (addr[TOP]),
    .addr_strobe (addr_strobe),
    .overlay     (overlay),
    .rom_cs_n    (rom_cs_n),
    .ram_cs_n    (ram_cs_n),
    .eff_a23     (eff_a23)
  );

endmodule

// File: rtl/boot_overlay_checker.sv
module boot_overlay_checker (
  input logic clk,
  input logic rst,
  input logic a_top,
  input logic addr_strobe,
  input logic rom_cs_n,
  input logic ram_cs_n,
  input logic eff_a23,
  input logic overlay,
  input logic pending,
  input logic wr_hit,
  input logic bus_end
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (rom_cs_n && ram_cs_n && eff_a23 && overlay));

  // R4
  cs_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rom_cs_n && !ram_cs_n));

  // R2
  overlay_rom_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr_strobe) && $past(overlay)) |-> (!rom_cs_n && ram_cs_n && eff_a23));

  // R3
  split_map_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr_strobe) && !$past(overlay)) |-> (rom_cs_n == !$past(a_top) && ram_cs_n == $past(a_top)));

  // R6
  no_stray_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (overlay && !pending && !wr_hit) |=> overlay);

  // R8
  defer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && !bus_end) |=> overlay);

  // R9
  no_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overlay) |-> $past(rst));

endmodule

bind boot_overlay_decoder boot_overlay_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .a_top       (addr[ADDR_W-1]),
  .addr_strobe (addr_strobe),
  .rom_cs_n    (rom_cs_n),
  .ram_cs_n    (ram_cs_n),
  .eff_a23     (eff_a23),
  .overlay     (overlay),
  .pending     (pending),
  .wr_hit      (wr_hit),
  .bus_end     (bus_end)
);

// File: tb/sim_boot_overlay_decoder.sv
`timescale 1ns/1ps
module sim_boot_overlay_decoder;

  localparam logic [23:0] IOA   = 24'hFFFFF0;
  localparam logic [7:0]  KEY   = 8'h5A;
  localparam int          DEFER = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] addr = '0;
  logic        addr_strobe = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_data = '0;
  logic        defer_en = 1'b0;
  logic        rom_cs_n, ram_cs_n, eff_a23;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  // bench model of the overlay
  bit m_ovl = 1, m_pend = 0, m_prev = 0;
  int m_left = 0;

  always #2 clk = ~clk;

  boot_overlay_decoder u0 (
    .clk(clk), .rst(rst), .addr(addr), .addr_strobe(addr_strobe),
    .io_wr(io_wr), .io_data(io_data), .defer_en(defer_en),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .eff_a23(eff_a23)
  );

  function automatic logic [2:0] expect_out(bit r, bit s, logic [23:0] a, bit ovl);
    bit e;
    e = a[23] | ovl;
    if (r) return 3'b111;
    return {~(s & e), ~(s & ~e), e};
  endfunction

  task automatic cyc(input bit r, input logic [23:0] a, input bit s,
                     input bit w, input logic [7:0] d, input string tag);
    logic [2:0] exp, act;
    bit hit, fin;
    @(negedge clk);
    rst = r; addr = a; addr_strobe = s; io_wr = w; io_data = d;
    exp = expect_out(r, s, a, m_ovl);
    hit = w && (a == IOA) && (d == KEY);
    fin = m_prev && !s;
    @(posedge clk);
    #1;
    act = {rom_cs_n, ram_cs_n, eff_a23};
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {rom_n,ram_n,eff} actual=%b expected=%b addr=%h", tag, act, exp, a);
    end
    if (r) begin
      m_ovl = 1; m_pend = 0; m_left = 0; m_prev = 0;
    end else begin
      if (hit && m_ovl && !m_pend) begin
        if (defer_en) begin m_pend = 1; m_left = DEFER; end
        else m_ovl = 0;
      end else if (m_pend && fin) begin
        m_left--;
        if (m_left == 0) begin m_pend = 0; m_ovl = 0; end
      end
      m_prev = s;
    end
  endtask

  task automatic do_reset(input bit dfr);
    defer_en = dfr;
    cyc(1, 24'h000000, 1, 0, 8'h00, "R1");
    cyc(1, 24'h123456, 0, 0, 8'h00, "R1");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    // ---- immediate mode ----
    do_reset(0);
    cyc(0, 24'h000000, 1, 0, 0, "R2 reset vector from ROM at zero");
    cyc(0, 24'h000004, 1, 0, 0, "R2");
    cyc(0, 24'h7FFFFC, 1, 0, 0, "R2");
    cyc(0, 24'h000000, 0, 0, 0, "R4 idle strobe");
    cyc(0, IOA, 0, 1, 8'h5B, "R6 wrong key");
    cyc(0, 24'hFFFFF4, 0, 1, KEY, "R6 wrong address");
    cyc(0, 24'h000100, 1, 0, 0, "R6 still ROM after stray writes");
    cyc(0, 24'h000100, 0, 0, 0, "R5");
    cyc(0, IOA, 0, 1, KEY, "R7 clearing write");
    cyc(0, 24'h000000, 1, 0, 0, "R7 RAM right after write");
    cyc(0, 24'h7FFFFF, 1, 0, 0, "R3 low half RAM");
    cyc(0, 24'h800000, 1, 0, 0, "R10");
    cyc(0, 24'h840000, 1, 0, 0, "R10");
    cyc(0, 24'h880000, 1, 0, 0, "R10");
    cyc(0, 24'hFC0000, 1, 0, 0, "R10");
    cyc(0, 24'hFFFFFF, 1, 0, 0, "R10");
    cyc(0, IOA, 0, 1, KEY, "R9 write after clear");
    cyc(0, 24'h000010, 1, 0, 0, "R9 stays RAM");
    cyc(0, 24'h000010, 0, 0, 0, "R4");
    // ---- deferred mode ----
    do_reset(1);
    cyc(0, 24'h000000, 1, 0, 0, "R1 overlay re-armed");
    cyc(0, IOA, 0, 1, KEY, "R8 write with completion same cycle");
    cyc(0, 24'h000020, 1, 0, 0, "R8 first bus cycle still ROM");
    cyc(0, 24'h000020, 1, 0, 0, "R8");
    cyc(0, IOA, 0, 1, KEY, "R9 write while pending, completion 1");
    cyc(0, 24'h000024, 1, 0, 0, "R8 second bus cycle still ROM");
    cyc(0, 24'h000024, 0, 0, 0, "R8 completion 2");
    cyc(0, 24'h000024, 1, 0, 0, "R8 now RAM");
    cyc(0, 24'h800024, 1, 0, 0, "R3 upper half ROM");
    cyc(0, 24'h000024, 0, 0, 0, "R4");
    // ---- random ----
    for (int i = 0; i < 4000; i++) begin
      logic [23:0] a;
      bit s, w, r;
      logic [7:0] d;
      int pick;
      pick = $urandom_range(0, 99);
      a = 24'($urandom);
      s = (pick < 60);
      w = (pick >= 92);
      d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : KEY;
      if (w && $urandom_range(0, 3) != 0) a = IOA;
      r = ($urandom_range(0, 299) == 0);
      if (r) defer_en = 1'($urandom);
      cyc(r, a, s, w, d, "R4 random traffic");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
  end

endmodule